// File: doc/BRIEF.md
# ADC Read Wait-Request Generator

This block sits on a processor bus in front of a slow analog-to-digital converter. The converter reports a running conversion on an active-low BUSY line. That line reacts too late to stretch a read cycle directly. When the processor starts a read of the converter, with the chip-select decode and the read strobe both low, the block drives an active-low wait request in that same clock period. It then holds the request for a programmable number of preset wait states, which covers the converter's slow BUSY response.

After the preset interval, the block follows a synchronized copy of BUSY and keeps the request active while the conversion runs. Once BUSY is seen released, it adds one more waited clock, because the converted data settles slightly after BUSY. A parameter sets a minimum number of waited clocks, so the bus cycle always covers the converter's access time plus setup and buffer delays. If the processor drops the read strobe or the chip select at any point, the request is released at once and the controller returns to idle.

Top module: `adc_wait_gen`

## Requirements
- R1: While rdN or csN is high, waitReqN is high in the same clock period. Holding csN low alone never asserts the request.
- R2: The clock period in which rdN and csN are both low from idle already shows waitReqN low, before any clock edge has passed. That edge is called edge 0.
- R3: presetWaits (0 to 3) is captured at edge 0. The request then stays low for that many further edges (edges 1..P), whatever BUSY does.
- R4: busyN passes through a two-flop synchronizer. The BUSY level the controller acts on at edge k is the busyN level sampled at edge k-2. Before the read, busyN is taken as high.
- R5: After the preset edges, the request stays low at every edge where the synchronized BUSY is still low.
- R6: The first edge k (k >= P+1) that sees synchronized BUSY high is followed by exactly one more waited edge, k+1, unless R7 asks for more.
- R7: The number of edges, counted from edge 0, at which waitReqN is low is max(k+2, MIN_WAIT). MIN_WAIT defaults to 6.
- R8: After the request releases, waitReqN stays high for as long as the read stays active.
- R9: A read that ends early, through rdN or csN going high, releases the request at once. The next read runs the complete sequence from edge 0.
- R10: A change on presetWaits after edge 0 has no effect on the current read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdN | input | 1 | Active-low read strobe |
| csN | input | 1 | Active-low chip select from address decode |
| busyN | input | 1 | Converter BUSY, low while a conversion runs (asynchronous) |
| presetWaits | input | PRESET_W (2) | Number of preset wait states, 0 to 3 |
| waitReqN | output | 1 | Active-low wait request to the processor |

## Verification
The embedded assertions check, on every cycle, the per-edge behaviour of the block:
- the immediate release when rdN or csN is high and the immediate assertion from idle;
- each stage of the BUSY synchronizer;
- the preset countdown;
- staying in the conversion wait while BUSY is low;
- the single step into the extra hold;
- the minimum-length hold;
- the sticky done state.

Only the bench scenarios show the end-to-end waited-edge totals, counted at the port against max(k+2, MIN_WAIT). These include reads where BUSY drops late, long conversions, aborts through either strobe, and a preset value changed in mid-read.

// File: rtl/wrg_pkg.sv
package wrg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PRESET   = 3'd1,
    ST_BUSYWAIT = 3'd2,
    ST_HOLD     = 3'd3,
    ST_DONE     = 3'd4
  } wrgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cycleStart;
    logic presetDec;
    logic waitTick;
  } wrgCtrl_s;

  // conditions from datapath to control
  typedef struct packed {
    logic presetZero;
    logic presetDone;
    logic convIdle;
    logic minMet;
  } wrgStat_s;

endpackage

// File: rtl/wrg_datapath.sv
module wrg_datapath
  import wrg_pkg::*;
#(
  parameter int PRESET_W    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WAIT    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busyN,
  input  logic [PRESET_W-1:0] presetWaits,
  input  wrgCtrl_s            ctrl,
  output wrgStat_s            stat
);

  localparam int CNT_W = $clog2(MIN_WAIT + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [PRESET_W-1:0]    presetCnt;
  logic [CNT_W-1:0]       waitCnt;
  logic                   warm;

  // BUSY synchronizer chain, reset to "not busy"
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= busyN;
        end
        p_sync_first_r4: assert property (@(posedge clk) disable iff (!rstN)
          warm |-> syncQ[0] == $past(busyN));
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b1;
          else       syncQ[i] <= syncQ[i-1];
        end
        p_sync_stage_r4: assert property (@(posedge clk) disable iff (!rstN)
          warm |-> syncQ[i] == $past(syncQ[i-1]));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= 1'b0;
    else       warm <= 1'b1;
  end

  // preset wait-state countdown, captured at the start of a read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               presetCnt <= '0;
    else if (ctrl.cycleStart) presetCnt <= presetWaits - PRESET_W'(1);
    else if (ctrl.presetDec)  presetCnt <= presetCnt - PRESET_W'(1);
  end

  // waited-edge counter, saturating at MIN_WAIT
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (ctrl.cycleStart) waitCnt <= CNT_W'(1);
    else if (ctrl.waitTick && waitCnt != CNT_W'(MIN_WAIT))
                              waitCnt <= waitCnt + CNT_W'(1);
  end

  always_comb begin
    stat.presetZero = (presetWaits == '0);
    stat.presetDone = (presetCnt == '0);
    stat.convIdle   = syncQ[SYNC_STAGES-1];
    stat.minMet     = (waitCnt >= CNT_W'(MIN_WAIT - 1));
  end

  p_preset_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.presetDec && !ctrl.cycleStart && presetCnt != '0)
      |=> presetCnt == $past(presetCnt) - PRESET_W'(1));

  p_preset_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.cycleStart && !ctrl.presetDec) |=> $stable(presetCnt));

  p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CNT_W'(MIN_WAIT));

endmodule

// File: rtl/wrg_control.sv
module wrg_control
  import wrg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdN,
  input  logic     csN,
  input  wrgStat_s stat,
  output wrgCtrl_s ctrl,
  output logic     waitReqN
);

  wrgState_e state, nextState;
  logic      readActive;

  assign readActive = !rdN && !csN;

  always_comb begin
    nextState = state;
    if (!readActive) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:     nextState = stat.presetZero ? ST_BUSYWAIT : ST_PRESET;
        ST_PRESET:   nextState = stat.presetDone ? ST_BUSYWAIT : ST_PRESET;
        ST_BUSYWAIT: nextState = stat.convIdle   ? ST_HOLD     : ST_BUSYWAIT;
        ST_HOLD:     nextState = stat.minMet     ? ST_DONE     : ST_HOLD;
        ST_DONE:     nextState = ST_DONE;
        default:     nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctrl.cycleStart = readActive && (state == ST_IDLE);
    ctrl.presetDec  = readActive && (state == ST_PRESET);
    ctrl.waitTick   = readActive && (state inside {ST_PRESET, ST_BUSYWAIT, ST_HOLD});
  end

  assign waitReqN = !(readActive && state != ST_DONE);

  p_start_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && readActive) |-> !waitReqN);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSYWAIT && !stat.convIdle && readActive)
      |=> (state == ST_BUSYWAIT));

  p_extra_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSYWAIT && stat.convIdle && readActive) |=> (state == ST_HOLD));

  p_min_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !stat.minMet && readActive) |=> (state == ST_HOLD));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && readActive) |=> (state == ST_DONE));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !readActive |=> (state == ST_IDLE));

endmodule

// File: rtl/adc_wait_gen.sv
module adc_wait_gen
  import wrg_pkg::*;
#(
  parameter int PRESET_W    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WAIT    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdN,
  input  logic                csN,
  input  logic                busyN,
  input  logic [PRESET_W-1:0] presetWaits,
  output logic                waitReqN
);

  wrgCtrl_s ctrl;
  wrgStat_s stat;

  wrg_datapath #(
    .PRESET_W   (PRESET_W),
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_WAIT   (MIN_WAIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busyN      (busyN),
    .presetWaits(presetWaits),
    .ctrl       (ctrl),
    .stat       (stat)
  );

  wrg_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .rdN     (rdN),
    .csN     (csN),
    .stat    (stat),
    .ctrl    (ctrl),
    .waitReqN(waitReqN)
  );

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdN || csN) |-> waitReqN);

endmodule

// File: tb/tb_adc_wait_gen.sv
`timescale 1ns/1ps
module tb_adc_wait_gen;

  localparam int MIN_WAIT = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdN = 1'b1;
  logic       csN = 1'b1;
  logic       busyN = 1'b1;
  logic [1:0] presetWaits = 2'd0;
  logic       waitReqN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  typedef struct {
    int    expCount;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  adc_wait_gen #(.MIN_WAIT(MIN_WAIT)) dut (
    .clk(clk), .rstN(rstN), .rdN(rdN), .csN(csN), .busyN(busyN),
    .presetWaits(presetWaits), .waitReqN(waitReqN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit busyLowAt(input int idx, input int l, input int d);
    return (d > 0) && (idx >= l) && (idx < l + d);
  endfunction

  // expected waited edges from R3..R7
  function automatic int expWaits(input int p, input int l, input int d);
    int k = p + 1;
    while (busyLowAt(k - 2, l, d)) k++;
    return (k + 2 > MIN_WAIT) ? k + 2 : MIN_WAIT;
  endfunction

  // driver: one read cycle held for holdEdges edges
  task automatic runRead(input int p, input int l, input int d, input int holdEdges,
                         input bit viaCs, input int newP, input string tag);
    int w = expWaits(p, l, d);
    expItem_t it;
    presetWaits = 2'(p);
    it.expCount = (w < holdEdges) ? w : holdEdges;
    it.tag = tag;
    expQ.push_back(it);
    for (int idx = 0; idx <= holdEdges; idx++) begin
      @(negedge clk);
      busyN = !busyLowAt(idx, l, d);
      if (idx == holdEdges) begin
        if (viaCs) csN = 1'b1;
        else       rdN = 1'b1;
      end else begin
        rdN = 1'b0;
        csN = 1'b0;
      end
      if (idx == 1 && newP >= 0) presetWaits = 2'(newP);
      #1;
      if (idx == 0)
        check(waitReqN == 1'b0, {tag, " R2 same-period assert"}, waitReqN, 0);
      if (idx == holdEdges - 1 && w < holdEdges)
        check(waitReqN == 1'b1, {tag, " R8 released while reading"}, waitReqN, 1);
      if (idx == holdEdges)
        check(waitReqN == 1'b1, {tag, " R9/R1 immediate release"}, waitReqN, 1);
    end
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1; busyN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: counts waited edges per read, compares against the queue
  initial begin : monitor
    bit wasActive = 1'b0;
    int cnt = 0;
    expItem_t it;
    forever begin
      @(negedge clk);
      #1;
      if (!rdN && !csN) begin
        if (!wasActive) cnt = 0;
        wasActive = 1'b1;
        if (!waitReqN) cnt++;
      end else if (wasActive) begin
        wasActive = 1'b0;
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected read end", cnt, -1);
        end else begin
          it = expQ.pop_front();
          check(cnt == it.expCount, {it.tag, " waited-edge count"}, cnt, it.expCount);
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 4);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    #1;
    check(waitReqN == 1'b1, "R1 reset state", waitReqN, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: chip select alone
    csN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(waitReqN == 1'b1, "R1 chip select only", waitReqN, 1);
    end

    // R7: no preset, no busy -> minimum rules
    runRead(0, 0, 0, 10, 1'b0, -1, "R7 minimum hold");
    // R5/R6: long conversion after full preset
    runRead(3, 1, 5, 14, 1'b0, -1, "R5 busy long");
    // R4/R5: busy low from the start, synchronizer delay counted
    runRead(2, 0, 8, 16, 1'b0, -1, "R4 sync latency");
    // R6: one extra edge beyond release decides the total
    runRead(1, 0, 3, 11, 1'b0, -1, "R6 extra hold");
    // R3: busy pulse inside preset window is ignored
    runRead(3, 0, 2, 10, 1'b0, -1, "R3 preset window");
    // R9: abort by read strobe during preset, then a full read
    runRead(3, 0, 10, 3, 1'b0, -1, "R9 abort by rd");
    runRead(0, 0, 0, 9, 1'b0, -1, "R9 read after abort");
    // R9: abort by chip select while waiting on busy
    runRead(1, 0, 12, 5, 1'b1, -1, "R9 abort by cs");
    // R10: preset changed after edge 0
    runRead(0, 2, 8, 16, 1'b0, 3, "R10 preset change ignored");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7 all reads observed", expQ.size(), 0);
    finishRun();
  end

endmodule